// File: doc/BRIEF.md
# Serial Word EEPROM Device Model

This block is a synthesizable slave that stands in for a small serial EEPROM of 16-bit words on a four-wire link. The four wires are chip select, serial clock, serial data in and serial data out. The host raises chip select and then clocks in an instruction one bit per rising serial-clock edge. The instruction is a start bit of 1, a two-bit opcode, an address field sent MSB first and, for the two commands that carry data, sixteen data bits sent MSB first. The model decodes the instruction and acts on an internal array of `2**ADDR_W` words. `ADDR_W` is 6 for the small arrangement and 8 for the large one.

The model samples the serial pins with the system clock `clk`. It treats a serial-clock rise as the first system-clock edge at which `sk` is high after having been low. The controller is one state machine. Its states are `ST_IDLE` (wait for a start bit), `ST_OPC` (two opcode bits), `ST_ADR` (address bits), `ST_DAT` (sixteen data bits), `ST_RDO` (shifting a read answer out) and `ST_HOLD` (instruction complete, wait for chip select to drop). Its transitions are as follows:
- idle to opcode on a sampled 1.
- opcode to address after two bits.
- address to read-out for a READ.
- address to data for WRITE and write-all.
- address to hold for every other command.
- data to hold after sixteen bits.
- any state to idle whenever chip select is low.

Programming commands take effect only after a write-enable command. A read answer starts with a dummy 0.

Top module: `serom_dev`

## Requirements
- R1: After reset the device is write-disabled, every word reads 16'hFFFF, and `do_o` is 1.
- R2: While `cs` is low, `do_o` is 1, including when `cs` drops partway through a read answer.
- R3: With `cs` high, a 0 sampled while waiting for a start bit is skipped. The first sampled 1 starts the instruction.
- R4: Opcode 10 is READ. On the rise that samples the last address bit, `do_o` goes to 0. Each later rise then presents the next word bit, starting at bit 15, and `do_o` changes at no other time while `cs` is high.
- R5: Opcode 01 is WRITE. When writes are enabled, the 16 data bits that follow the address replace the addressed word.
- R6: Opcode 11 is ERASE. When writes are enabled, the addressed word becomes 16'hFFFF.
- R7: With opcode 00, the top two address bits choose the command: 11 enables writes and 00 disables them. The remaining address bits are don't-care.
- R8: Opcode 00 with top address bits 10 is erase-all. When writes are enabled, every word becomes 16'hFFFF.
- R9: Opcode 00 with top address bits 01 is write-all. When writes are enabled, every word takes the 16 data bits that follow.
- R10: While writes are disabled, WRITE, ERASE, erase-all and write-all leave every word unchanged.
- R11: Dropping `cs` before an instruction is complete discards it. The next instruction decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data to the host, high when idle |

## Verification
A wrong bit counter or a missed edge moves the read answer by one position. This shows on the very first read, either as a dummy bit that is not 0 or as a word shifted against its expected value. A write-enable flag that is set or cleared at the wrong time, or a misread command field under opcode 00, stays hidden until the next read of a word the command touched. The checks therefore follow every programming command with a read within one instruction. A decoder that fails to return to idle when chip select falls shows as a garbled decode of the following instruction, or as `do_o` not going high within one system clock.

// File: rtl/serom_pkg.sv
package serom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RDO,
        ST_HOLD
    } serom_state_e;

    // Opcode values as they arrive on the wire (first bit is the MSB).
    localparam logic [1:0] OP_SYS = 2'b00;
    localparam logic [1:0] OP_WR  = 2'b01;
    localparam logic [1:0] OP_RD  = 2'b10;
    localparam logic [1:0] OP_ER  = 2'b11;

    // Sub-command carried in the top two address bits under OP_SYS.
    localparam logic [1:0] SYS_WDIS = 2'b00;
    localparam logic [1:0] SYS_WALL = 2'b01;
    localparam logic [1:0] SYS_EALL = 2'b10;
    localparam logic [1:0] SYS_WENA = 2'b11;

endpackage

// File: rtl/serom_sk_edge.sv
module serom_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic rise
);
    logic sk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign rise = sk & ~sk_q;
endmodule

// File: rtl/serom_word_array.sv
module serom_word_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;

        assign hit = we && (all || (waddr == ADDR_W'(g)));

        always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '1;
            else if (hit) word_q <= wdata;
        end

        assign words[g] = word_q;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/serom_ctrl.sv
module serom_ctrl
    import serom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rise,
    input  logic              di,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              mem_we,
    output logic              mem_all,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              do_o,
    output serom_state_e      state_o,
    output logic              wen_o
);
    localparam int MAXB = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);

    serom_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [WORD_W-1:0] data_q, data_nxt;
    logic [WORD_W-1:0] sr_q;
    logic              wen_q;
    logic              do_q;
    logic              step;
    logic              last_adr, last_dat;
    logic [1:0]        sys_sel;
    logic              ena_hit, dis_hit, prog_req, rd_load, shift;

    // Datapath helpers and the command decode for the current edge.
    always_comb begin
        step     = cs && rise;
        addr_nxt = {addr_q[ADDR_W-2:0], di};
        data_nxt = {data_q[WORD_W-2:0], di};
        sys_sel  = addr_nxt[ADDR_W-1 -: 2];
        last_adr = step && (state_q == ST_ADR) && (cnt_q == ADR_LAST);
        last_dat = step && (state_q == ST_DAT) && (cnt_q == DAT_LAST);
        ena_hit  = last_adr && (op_q == OP_SYS) && (sys_sel == SYS_WENA);
        dis_hit  = last_adr && (op_q == OP_SYS) && (sys_sel == SYS_WDIS);
        prog_req = last_dat
                 || (last_adr && (op_q == OP_ER))
                 || (last_adr && (op_q == OP_SYS) && (sys_sel == SYS_EALL));
        rd_load  = last_adr && (op_q == OP_RD);
        shift    = step && (state_q == ST_RDO);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!cs) begin
            state_d = ST_IDLE;
        end else if (rise) begin
            unique case (state_q)
                ST_IDLE: if (di) state_d = ST_OPC;
                ST_OPC:  if (cnt_q == CNT_W'(1)) state_d = ST_ADR;
                ST_ADR: begin
                    if (cnt_q == ADR_LAST) begin
                        if (op_q == OP_RD)
                            state_d = ST_RDO;
                        else if (op_q == OP_WR || (op_q == OP_SYS && sys_sel == SYS_WALL))
                            state_d = ST_DAT;
                        else
                            state_d = ST_HOLD;
                    end
                end
                ST_DAT:  if (cnt_q == DAT_LAST) state_d = ST_HOLD;
                ST_RDO:  state_d = ST_RDO;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter, shift registers and write-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
            sr_q   <= '1;
            wen_q  <= 1'b0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (step)          cnt_q <= cnt_q + CNT_W'(1);

            if (step) begin
                unique case (state_q)
                    ST_OPC:  op_q   <= {op_q[0], di};
                    ST_ADR:  addr_q <= addr_nxt;
                    ST_DAT:  data_q <= data_nxt;
                    default: ;
                endcase
            end

            if (ena_hit)      wen_q <= 1'b1;
            else if (dis_hit) wen_q <= 1'b0;

            if (rd_load)    sr_q <= rd_data;
            else if (shift) sr_q <= {sr_q[WORD_W-2:0], 1'b1};
        end
    end

    // Serial output register.
    always_ff @(posedge clk) begin
        if (!rst_n)       do_q <= 1'b1;
        else if (!cs)     do_q <= 1'b1;
        else if (rd_load) do_q <= 1'b0;
        else if (shift)   do_q <= sr_q[WORD_W-1];
    end

    assign rd_addr   = addr_nxt;
    assign mem_we    = prog_req && wen_q;
    assign mem_all   = (op_q == OP_SYS);
    assign mem_addr  = (state_q == ST_ADR) ? addr_nxt : addr_q;
    assign mem_wdata = last_dat ? data_nxt : '1;
    assign do_o      = do_q;
    assign state_o   = state_q;
    assign wen_o     = wen_q;
endmodule

// File: rtl/serom_dev.sv
module serom_dev
    import serom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o
);
    logic              sk_rise;
    logic [ADDR_W-1:0] rd_addr, mem_addr;
    logic [WORD_W-1:0] rd_data, mem_wdata;
    logic              mem_we, mem_all;
    serom_state_e      dec_state;
    logic              dec_wen;

    serom_sk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sk   (sk),
        .rise (sk_rise)
    );

    serom_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .rise     (sk_rise),
        .di       (di),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .mem_we   (mem_we),
        .mem_all  (mem_all),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .do_o     (do_o),
        .state_o  (dec_state),
        .wen_o    (dec_wen)
    );

    serom_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .all  (mem_all),
        .waddr(mem_addr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/serom_dev_chk.sv
module serom_dev_chk
    import serom_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cs,
    input logic         sk,
    input logic         do_o,
    input serom_state_e st,
    input logic         wen
);
    logic sk_d;
    logic sk_up;

    always_ff @(posedge clk) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= sk;
    end

    assign sk_up = sk && !sk_d;

    assert_do_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> do_o);

    assert_do_moves_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(do_o) |-> ($past(sk_up) || $past(!cs)));

    assert_wen_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen) |-> $past(sk_up && cs));

    assert_idle_after_cs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (st == ST_IDLE));

    assert_reset_disabled_R1: assert property (@(posedge clk)
        !rst_n |=> !wen);
endmodule

bind serom_dev serom_dev_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (cs),
    .sk   (sk),
    .do_o (do_o),
    .st   (dec_state),
    .wen  (dec_wen)
);

// File: tb/serom_dev_test.sv
module serom_dev_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic do_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serom_dev uut (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (cs),
        .sk   (sk),
        .di   (di),
        .do_o (do_o)
    );

    localparam logic [2:0] K_ENA = 3'd0, K_DIS = 3'd1, K_WR = 3'd2, K_ER = 3'd3,
                           K_EALL = 3'd4, K_WALL = 3'd5, K_RD = 3'd6;

    typedef struct packed {
        logic [2:0]  kind;
        logic [5:0]  adr;
        logic [15:0] dat;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{K_RD,   6'd5,  16'hFFFF},  // R1 erased after reset
        '{K_WR,   6'd5,  16'h1234},  // R10 disabled write
        '{K_RD,   6'd5,  16'hFFFF},  // R10
        '{K_ENA,  6'd0,  16'h0000},  // R7 enable
        '{K_WR,   6'd5,  16'hA5C3},  // R5
        '{K_RD,   6'd5,  16'hA5C3},  // R5
        '{K_WR,   6'd63, 16'h8001},  // R5 top address
        '{K_RD,   6'd63, 16'h8001},  // R5
        '{K_RD,   6'd0,  16'hFFFF},  // R5 neighbour untouched
        '{K_ER,   6'd5,  16'h0000},  // R6
        '{K_RD,   6'd5,  16'hFFFF},  // R6
        '{K_WALL, 6'd0,  16'h3C5A},  // R9
        '{K_RD,   6'd0,  16'h3C5A},  // R9
        '{K_RD,   6'd37, 16'h3C5A},  // R9
        '{K_EALL, 6'd0,  16'h0000},  // R8
        '{K_RD,   6'd63, 16'hFFFF},  // R8
        '{K_WR,   6'd10, 16'h0F0F},  // R5
        '{K_DIS,  6'd0,  16'h0000},  // R7 disable
        '{K_WR,   6'd10, 16'h1111},  // R10
        '{K_RD,   6'd10, 16'h0F0F},  // R7 R10
        '{K_EALL, 6'd0,  16'h0000},  // R10 disabled erase-all
        '{K_RD,   6'd10, 16'h0F0F}   // R10
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        di = b;
        sk = 1'b0;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_on();
        sk = 1'b0;
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_off();
        sk = 1'b0;
        di = 1'b0;
        cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [5:0] a,
                            input bit has_data, input logic [15:0] d);
        cs_on();
        send_hdr(op, a);
        if (has_data) for (int i = 15; i >= 0; i--) clk_bit(d[i]);
        cs_off();
    endtask

    task automatic do_read(input logic [5:0] a, input int nlead,
                           output logic [15:0] word, output logic dummy, output logic steady);
        logic prev;
        cs_on();
        for (int i = 0; i < nlead; i++) clk_bit(1'b0);
        send_hdr(2'b10, a);
        dummy = do_o;
        prev = do_o;
        steady = 1'b1;
        word = '0;
        for (int i = 15; i >= 0; i--) begin
            di = 1'b0;
            sk = 1'b0;
            repeat (4) @(negedge clk);
            if (do_o !== prev) steady = 1'b0;
            sk = 1'b1;
            repeat (4) @(negedge clk);
            word[i] = do_o;
            prev = do_o;
        end
        cs_off();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic dm, st;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 do_o idle after reset", {15'd0, do_o}, 16'd1);

        for (int v = 0; v < NV; v++) begin
            unique case (VECS[v].kind)
                K_ENA:  send_cmd(2'b00, 6'b110000, 1'b0, '0);
                K_DIS:  send_cmd(2'b00, 6'b000000, 1'b0, '0);
                K_WR:   send_cmd(2'b01, VECS[v].adr, 1'b1, VECS[v].dat);
                K_ER:   send_cmd(2'b11, VECS[v].adr, 1'b0, '0);
                K_EALL: send_cmd(2'b00, 6'b100000, 1'b0, '0);
                K_WALL: send_cmd(2'b00, 6'b010000, 1'b1, VECS[v].dat);
                default: begin
                    do_read(VECS[v].adr, 0, w, dm, st);
                    chk($sformatf("R4 dummy bit, vector %0d", v), {15'd0, dm}, 16'd0);
                    chk($sformatf("table word, vector %0d", v), w, VECS[v].dat);
                end
            endcase
        end

        // R7: don't-care low bits under opcode 00 and enable again.
        send_cmd(2'b00, 6'b111011, 1'b0, '0);
        send_cmd(2'b01, 6'd7, 1'b1, 16'h1234);
        do_read(6'd7, 0, w, dm, st);
        chk("R7 enable with don't-care bits", w, 16'h1234);
        chk("R4 output steady between rises", {15'd0, st}, 16'd1);

        // R3: leading zeros before the start bit.
        do_read(6'd7, 3, w, dm, st);
        chk("R3 leading zeros skipped", w, 16'h1234);
        chk("R3 dummy bit", {15'd0, dm}, 16'd0);

        // R11: write aborted halfway through its data.
        cs_on();
        send_hdr(2'b01, 6'd7);
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
        cs_off();
        do_read(6'd7, 0, w, dm, st);
        chk("R11 aborted write discarded", w, 16'h1234);

        // R11: aborted erase header (cs drops inside address field).
        cs_on();
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b0);
        cs_off();
        do_read(6'd7, 0, w, dm, st);
        chk("R11 aborted erase discarded", w, 16'h1234);

        // R2: cs dropped in the middle of a read answer.
        cs_on();
        send_hdr(2'b10, 6'd7);
        for (int i = 0; i < 4; i++) clk_bit(1'b0);
        cs = 1'b0;
        sk = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 do_o high after cs low", {15'd0, do_o}, 16'd1);
        repeat (2) @(negedge clk);
        do_read(6'd7, 0, w, dm, st);
        chk("R2 R11 read after abort", w, 16'h1234);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule